// File: doc/BRIEF.md
# Change-Driven Sample Capture Unit

This block records a parallel channel bus into on-chip acquisition memory. Memory is not filled at a fixed rate. A sample is written only when the sampled word differs from the word stored last. Each stored entry carries a tag that gives the distance to the previous stored entry, so the waveform can be rebuilt later with the correct spacing. Because of this, how much time a full memory covers depends on how often the data changes, not on depth times sample period.

A run begins on `runStart`. It ends when `runStop` is asserted or when the entry capacity is reached. The tag can count clock cycles (time tagging) or qualified samples (state tagging). With tags enabled, the tag shares each memory slot's budget, so the usable capacity is half the depth. After the run, a host steps a registered read port through the entries. Each read returns the tag and the data as one word.

Top module: `chgCapture`

## Requirements
- R1: After reset, `capturing` is 0, `full` is 0 and `entryCount` is 0.
- R2: The first qualified sample (`smpValid`=1) after `runStart` is always stored, whatever its value, and its tag is 0.
- R3: Each later qualified sample is stored only when its data differs from the last stored data. A stored sample raises `entryCount` by one.
- R4: With `tagMode`=0 and `tagEn`=1, a stored entry's tag equals the number of clock cycles since the previous stored entry.
- R5: With `tagMode`=1 and `tagEn`=1, a stored entry's tag equals the number of qualified samples since the previous stored entry, counting the new one.
- R6: A tag saturates at 2^TAG_W-1 and does not wrap.
- R7: With `tagEn`=0, every stored tag field is 0 and the capacity is DEPTH entries. With `tagEn`=1, the capacity is DEPTH/2 entries.
- R8: When `entryCount` reaches the capacity, `full` is 1, `capturing` drops to 0 and later samples are not stored.
- R9: `runStop` during a run ends the run. The sample presented in the stop cycle and all later samples are not stored.
- R10: `runStart` clears `entryCount` and begins a new run. The first sample of that run is stored even if it equals the last word of the previous run.
- R11: One clock after `rdAddr` is applied, `rdWord` holds entry `rdAddr`, with the tag in bits [TAG_W+DATA_W-1:DATA_W] and the data in bits [DATA_W-1:0].
- R12: A cycle with `smpValid`=0 stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runStart | input | 1 | Begin a new run (takes priority over stop) |
| runStop | input | 1 | End the current run |
| tagEn | input | 1 | Store tags and halve the capacity |
| tagMode | input | 1 | 0: count clock cycles, 1: count qualified samples |
| smpValid | input | 1 | Sample qualifier |
| smpData | input | DATA_W | Channel bus sample |
| rdAddr | input | $clog2(DEPTH) | Read entry index |
| rdWord | output | TAG_W+DATA_W | Registered {tag, data} of the entry |
| capturing | output | 1 | A run is in progress |
| full | output | 1 | Entry count has reached the capacity |
| entryCount | output | $clog2(DEPTH)+1 | Entries stored in this run |

## Verification
The bench builds the block with DATA_W=8, TAG_W=4 and DEPTH=16. The 4-bit tag makes saturation at 15 reachable after a 20-cycle gap. The 16-entry depth lets both capacities, 16 untagged and 8 tagged, be filled and overrun in a few dozen cycles. The 8-bit data leaves enough room for distinct, repeated and reset-equal values, which exercise the forced first store and the change comparison.

// File: rtl/chgCapture_pkg.sv
package chgCapture_pkg;
  typedef struct packed {
    logic clear;
    logic tick;
    logic write;
    logic first;
  } capStrobe_t;
endpackage

// File: rtl/chgCaptureCtrl.sv
module chgCaptureCtrl
  import chgCapture_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       runStart,
  input  logic                       runStop,
  input  logic                       tagEn,
  input  logic                       tagMode,
  input  logic                       smpValid,
  input  logic                       isChange,
  output capStrobe_t                 strb,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       capturing,
  output logic                       full
);
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam logic [CNT_W-1:0] CAP_ALL  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CAP_HALF = CNT_W'(DEPTH / 2);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} runState_t;
  runState_t state;
  logic firstPend;
  logic [CNT_W-1:0] capLimit;
  logic active;

  assign capLimit  = tagEn ? CAP_HALF : CAP_ALL;
  assign full      = (count >= capLimit);
  assign capturing = (state == ST_RUN);
  assign active    = capturing && !runStart && !runStop;

  always_comb begin
    strb.clear = runStart;
    strb.first = firstPend;
    strb.tick  = active && (tagMode ? smpValid : 1'b1);
    strb.write = active && smpValid && (firstPend || isChange) && !full;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      count     <= '0;
      firstPend <= 1'b0;
    end else if (runStart) begin
      state     <= ST_RUN;
      count     <= '0;
      firstPend <= 1'b1;
    end else if (state == ST_RUN) begin
      if (runStop) begin
        state <= ST_DONE;
      end else if (strb.write) begin
        count     <= count + 1'b1;
        firstPend <= 1'b0;
        if (count + 1'b1 >= capLimit) state <= ST_DONE;
      end
    end
  end

  // R8: entry count never exceeds the physical depth
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    count <= CAP_ALL);

  // R3: count only holds or steps by one while no restart occurs
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    !runStart |=> (count == $past(count) || count == $past(count) + 1'b1));

  // R9: a stop without restart ends the run on the next cycle
  p_stop_ends_r9: assert property (@(posedge clk) disable iff (!rstN)
    (capturing && runStop && !runStart) |=> !capturing);

  // R8: reaching capacity ends the run
  p_full_halts_r8: assert property (@(posedge clk) disable iff (!rstN)
    (capturing && strb.write && !runStart && (count + 1'b1 >= capLimit)) |=> !capturing);
endmodule

// File: rtl/chgCaptureData.sv
module chgCaptureData
  import chgCapture_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 32,
  parameter int DEPTH  = 512
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  capStrobe_t                 strb,
  input  logic                       tagEn,
  input  logic [DATA_W-1:0]          smpData,
  input  logic [$clog2(DEPTH)-1:0]   wrAddr,
  input  logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic                       isChange,
  output logic [TAG_W+DATA_W-1:0]    rdWord
);
  localparam int WORD_W = TAG_W + DATA_W;
  localparam logic [TAG_W-1:0] TAG_MAX = {TAG_W{1'b1}};

  logic [DATA_W-1:0] lastWord;
  logic [TAG_W-1:0]  tagCnt;
  logic [TAG_W-1:0]  tagNext;
  logic [TAG_W-1:0]  storeTag;
  logic [WORD_W-1:0] mem [DEPTH];

  assign isChange = (smpData != lastWord);
  assign tagNext  = (tagCnt == TAG_MAX) ? TAG_MAX : tagCnt + 1'b1;
  assign storeTag = (!tagEn || strb.first) ? '0 : tagNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastWord <= '0;
      tagCnt   <= '0;
    end else begin
      if (strb.write) lastWord <= smpData;
      if (strb.clear || strb.write) tagCnt <= '0;
      else if (strb.tick)           tagCnt <= tagNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.write) mem[wrAddr] <= {storeTag, smpData};
    rdWord <= mem[rdAddr];
  end

  // R3: the reference word follows the stored sample
  p_last_word_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.write |=> lastWord == $past(smpData));

  // R6: a saturated tag counter stays saturated until a store or restart
  p_tag_sat_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tagCnt == TAG_MAX && !strb.clear && !strb.write) |=> tagCnt == TAG_MAX);
endmodule

// File: rtl/chgCapture.sv
module chgCapture
  import chgCapture_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 32,
  parameter int DEPTH  = 512
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          runStart,
  input  logic                          runStop,
  input  logic                          tagEn,
  input  logic                          tagMode,
  input  logic                          smpValid,
  input  logic [DATA_W-1:0]             smpData,
  input  logic [$clog2(DEPTH)-1:0]      rdAddr,
  output logic [TAG_W+DATA_W-1:0]       rdWord,
  output logic                          capturing,
  output logic                          full,
  output logic [$clog2(DEPTH):0]        entryCount
);
  localparam int ADDR_W = $clog2(DEPTH);

  capStrobe_t strb;
  logic isChange;

  chgCaptureCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .runStart(runStart), .runStop(runStop),
    .tagEn(tagEn), .tagMode(tagMode), .smpValid(smpValid),
    .isChange(isChange), .strb(strb), .count(entryCount),
    .capturing(capturing), .full(full)
  );

  chgCaptureData #(.DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .tagEn(tagEn), .smpData(smpData),
    .wrAddr(entryCount[ADDR_W-1:0]), .rdAddr(rdAddr),
    .isChange(isChange), .rdWord(rdWord)
  );
endmodule

// File: tb/sim_chgCapture.sv
module sim_chgCapture;
  localparam int DW = 8;
  localparam int TW = 4;
  localparam int DP = 16;
  localparam int AW = $clog2(DP);
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runStart = 1'b0, runStop = 1'b0, tagEn = 1'b1, tagMode = 1'b0, smpValid = 1'b0;
  logic [DW-1:0] smpData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [TW+DW-1:0] rdWord;
  logic capturing, full;
  logic [AW:0] entryCount;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  chgCapture #(.DATA_W(DW), .TAG_W(TW), .DEPTH(DP)) u0 (
    .clk(clk), .rstN(rstN), .runStart(runStart), .runStop(runStop),
    .tagEn(tagEn), .tagMode(tagMode), .smpValid(smpValid), .smpData(smpData),
    .rdAddr(rdAddr), .rdWord(rdWord), .capturing(capturing), .full(full),
    .entryCount(entryCount)
  );

  // {valid, data, expect stored, expected tag}
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 8'h00, 1'b1, 4'd0},
    {1'b1, 8'h00, 1'b0, 4'd0},
    {1'b0, 8'h55, 1'b0, 4'd0},
    {1'b1, 8'h55, 1'b1, 4'd3},
    {1'b1, 8'hAA, 1'b1, 4'd1},
    {1'b1, 8'hAA, 1'b0, 4'd0},
    {1'b1, 8'hAA, 1'b0, 4'd0},
    {1'b1, 8'h0F, 1'b1, 4'd3},
    {1'b0, 8'h0F, 1'b0, 4'd0},
    {1'b1, 8'hF0, 1'b1, 4'd2}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply inputs for exactly one rising edge; returns at the following falling edge
  task automatic cyc(input logic v, input logic [DW-1:0] d, input logic st, input logic sp);
    smpValid = v; smpData = d; runStart = st; runStop = sp;
    @(posedge clk);
    @(negedge clk);
    smpValid = 1'b0; runStart = 1'b0; runStop = 1'b0;
  endtask

  task automatic rd(input int a, output logic [TW+DW-1:0] w);
    rdAddr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    w = rdWord;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    finished = 1;
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [TW+DW-1:0] w;
    logic [TW+DW-1:0] expWords [NV];
    int nStored;
    int lastIdx;
    int expCnt;

    repeat (3) @(negedge clk);
    chk("R1 capturing", int'(capturing), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 count", int'(entryCount), 0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: time tagging, tags enabled
    tagEn = 1'b1; tagMode = 1'b0;
    cyc(1'b0, '0, 1'b1, 1'b0);
    chk("R10 capturing after start", int'(capturing), 1);
    nStored = 0; lastIdx = -1; expCnt = 0;
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][13], VEC[i][12:5], 1'b0, 1'b0);
      if (VEC[i][4]) begin
        expCnt++;
        // R4 / R2: expected tag from cycle distance to previous store
        expWords[nStored] = {(lastIdx < 0) ? 4'd0 : 4'(i - lastIdx), VEC[i][12:5]};
        chk("R4 table tag", int'(VEC[i][3:0]), int'(expWords[nStored][DW +: TW]));
        nStored++;
        lastIdx = i;
      end
      chk("R3 R12 count per step", int'(entryCount), expCnt);
    end
    for (int i = 0; i < nStored; i++) begin
      rd(i, w);
      chk("R11 R4 readback", int'(w), int'(expWords[i]));
    end

    // R5 state tagging
    tagMode = 1'b1;
    cyc(1'b0, '0, 1'b1, 1'b0);
    cyc(1'b1, 8'h01, 1'b0, 1'b0);
    repeat (3) cyc(1'b0, 8'h07, 1'b0, 1'b0);
    cyc(1'b1, 8'h01, 1'b0, 1'b0);
    cyc(1'b0, 8'h09, 1'b0, 1'b0);
    cyc(1'b1, 8'h02, 1'b0, 1'b0);
    chk("R5 count", int'(entryCount), 2);
    rd(0, w); chk("R2 first entry state mode", int'(w), int'({4'd0, 8'h01}));
    rd(1, w); chk("R5 state tag", int'(w), int'({4'd2, 8'h02}));

    // R6 saturation in time mode
    tagMode = 1'b0;
    cyc(1'b0, '0, 1'b1, 1'b0);
    cyc(1'b1, 8'h01, 1'b0, 1'b0);
    repeat (20) cyc(1'b0, 8'h00, 1'b0, 1'b0);
    cyc(1'b1, 8'h02, 1'b0, 1'b0);
    rd(1, w); chk("R6 saturated tag", int'(w), int'({4'hF, 8'h02}));

    // R7/R8 untagged capacity DEPTH
    tagEn = 1'b0;
    cyc(1'b0, '0, 1'b1, 1'b0);
    for (int i = 0; i < DP + 1; i++) cyc(1'b1, 8'(i + 1), 1'b0, 1'b0);
    chk("R7 untagged capacity", int'(entryCount), DP);
    chk("R8 full", int'(full), 1);
    chk("R8 capturing dropped", int'(capturing), 0);
    rd(DP - 1, w); chk("R7 untagged tag zero", int'(w), int'({4'd0, 8'(DP)}));

    // R7/R8 tagged capacity DEPTH/2
    tagEn = 1'b1;
    cyc(1'b0, '0, 1'b1, 1'b0);
    chk("R10 count cleared", int'(entryCount), 0);
    chk("R10 full cleared", int'(full), 0);
    for (int i = 0; i < DP / 2 + 2; i++) cyc(1'b1, 8'(8'h40 + i), 1'b0, 1'b0);
    chk("R7 tagged capacity", int'(entryCount), DP / 2);
    chk("R8 full tagged", int'(full), 1);
    rd(DP / 2 - 1, w); chk("R8 last slot", int'(w), int'({4'd1, 8'(8'h40 + DP / 2 - 1)}));

    // R9 stop
    cyc(1'b0, '0, 1'b1, 1'b0);
    cyc(1'b1, 8'h01, 1'b0, 1'b0);
    cyc(1'b1, 8'h02, 1'b0, 1'b1);
    chk("R9 stop cycle not stored", int'(entryCount), 1);
    chk("R9 capturing after stop", int'(capturing), 0);
    cyc(1'b1, 8'h03, 1'b0, 1'b0);
    chk("R9 after stop ignored", int'(entryCount), 1);

    // R10 restart with a word equal to the previous last word
    cyc(1'b0, '0, 1'b1, 1'b0);
    cyc(1'b1, 8'h01, 1'b0, 1'b0);
    chk("R10 first stored after restart", int'(entryCount), 1);
    rd(0, w); chk("R10 R2 entry zero", int'(w), int'({4'd0, 8'h01}));

    finish_run();
  end
endmodule